// File: doc/BRIEF.md
# Split-Coefficient Distributed Arithmetic Evaluator

This block produces one partial sum of a distributed-arithmetic dot product. It receives a vector of sample bits, one bit per tap, all taken from the same bit position of the input samples. It returns the sum of the constant coefficients whose select bit is set. A bit-serial accumulator around the block weights these partial sums by their bit positions and adds them up.

The lookup table is not indexed by full coefficients. Each coefficient is split at bit LOW_W into a signed upper part and an unsigned lower part of LOW_W bits. One constant table sums the upper parts and a second sums the lower parts. Both tables are addressed by the same select vector. The upper result is shifted left by LOW_W and added to the lower result. This keeps each table's word narrow.

The upper table can itself be split into tap groups of GROUP_A taps each. The group results are added before the first register. The lookup stage and the shift-add stage are each registered, so the latency is a fixed two cycles at a throughput of one vector per cycle.

Top module: `split_coef_da`

## Requirements
- R1: While reset is asserted and after its release, until a valid vector has passed the pipeline, out_valid is 0 and out_sum is 0.
- R2: out_valid is 1 exactly two clock cycles after each cycle in which in_valid is 1, and 0 otherwise.
- R3: For a valid vector, out_sum equals the two's-complement sum of COEFS[i] over every i where bit i of in_bits is 1. The result is $clog2(N_TAPS)+COEF_W bits wide.
- R4: An all-zero valid vector gives out_sum = 0.
- R5: An all-ones valid vector gives the sum of all coefficients, including the most negative value the coefficient width allows.
- R6: Vectors that select only negative coefficients give the correct negative sum, even when the lower LOW_W bits of those coefficients are nonzero.
- R7: A cycle with in_valid = 0 has no effect on the output: out_sum keeps the last delivered result, whatever in_bits carries.
- R8: When GROUP_A < N_TAPS, the upper table is built as ceil(N_TAPS/GROUP_A) tap-group tables, the last one possibly smaller. The results are the same as with one table.
- R9: Valid vectors on consecutive cycles each produce their own correct result on consecutive cycles.
- R10: Elaboration fails unless 0 < LOW_W < COEF_W, GROUP_A >= 1, and every coefficient fits COEF_W signed bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks in_bits as a vector to evaluate |
| in_bits | input | N_TAPS | Select bits, bit i selects coefficient i |
| out_valid | output | 1 | Result on out_sum is new this cycle |
| out_sum | output | $clog2(N_TAPS)+COEF_W | Signed partial sum |

## Verification
The hardest case to reach is one where the recombination carries across the split point. This happens when the lower-part sum overflows past LOW_W bits while the upper-part sum is negative, so sign extension and the carry must interact correctly. The stimulus reaches it by sweeping all 64 select vectors back to back on two instances. One instance uses coefficients with large negative values and nonzero low bits, and it splits its upper table unevenly (4 taps + 2 taps). Random vectors with gaps between them follow the sweep, together with garbage on in_bits during idle cycles to check that the output holds.

// File: rtl/split_da_pkg.sv
package split_da_pkg;

   // signed upper part of a coefficient above the split point
   function automatic int upper_part(input int coef, input int split);
      return coef >>> split;
   endfunction

   // unsigned lower part, split bits wide
   function automatic int lower_part(input int coef, input int split);
      return coef & ((1 << split) - 1);
   endfunction

endpackage

// File: rtl/split_da_rom.sv
module split_da_rom #(
   parameter int NC          = 6,
   parameter int COEFS [NC]  = '{1, 2, 3, 4, 5, 6},
   parameter int BASE        = 0,
   parameter int TAPS        = 6,
   parameter int SPLIT       = 5,
   parameter bit UPPER       = 1'b1,
   parameter int WORD_W      = 8
) (
   input  logic [TAPS-1:0]   addr,
   output logic [WORD_W-1:0] word
);
   import split_da_pkg::*;

   localparam int DEPTH = 1 << TAPS;

   if (BASE + TAPS > NC) begin : g_bad_range
      $error("tap window exceeds coefficient count");
   end

   function automatic int entry(input int a);
      int acc;
      acc = 0;
      for (int i = 0; i < TAPS; i++) begin
         if (((a >> i) & 1) != 0) begin
            if (UPPER) acc += upper_part(COEFS[BASE+i], SPLIT);
            else       acc += lower_part(COEFS[BASE+i], SPLIT);
         end
      end
      return acc;
   endfunction

   logic [WORD_W-1:0] table_q [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_entry
      localparam int VAL = entry(a);
      assign table_q[a] = VAL[WORD_W-1:0];
   end

   assign word = table_q[addr];

endmodule

// File: rtl/split_da_merge.sv
module split_da_merge #(
   parameter int HI_W   = 6,
   parameter int LO_W   = 8,
   parameter int SPLIT  = 5,
   parameter int OUT_W  = 11,
   parameter int HI_MIN = -32,
   parameter int HI_MAX = 31,
   parameter int LO_MAX = 255
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_in,
   input  logic signed [HI_W-1:0]  hi_in,
   input  logic [LO_W-1:0]         lo_in,
   output logic                    vld_out,
   output logic signed [OUT_W-1:0] sum_out
);
   logic signed [OUT_W-1:0] hi_x;
   logic signed [OUT_W-1:0] lo_x;
   logic signed [OUT_W-1:0] sum_d;

   always_comb begin
      hi_x  = OUT_W'(hi_in);
      lo_x  = $signed(OUT_W'(lo_in));
      sum_d = (hi_x <<< SPLIT) + lo_x;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_out <= 1'b0;
         sum_out <= '0;
      end else begin
         vld_out <= vld_in;
         if (vld_in) sum_out <= sum_d;
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in |=> vld_out);
   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_in |=> (!vld_out && $stable(sum_out)));
   // R3
   lower_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in |-> (int'(lo_in) <= LO_MAX));
   // R6
   upper_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in |-> (int'(hi_in) >= HI_MIN && int'(hi_in) <= HI_MAX));

endmodule

// File: rtl/split_coef_da.sv
module split_coef_da #(
   parameter int N_TAPS           = 6,
   parameter int COEF_W           = 8,
   parameter int LOW_W            = 5,
   parameter int GROUP_A          = 6,
   parameter int COEFS [N_TAPS]   = '{23, -53, -108, -79, 55, 127},
   localparam int LOG_N           = $clog2(N_TAPS),
   localparam int OUT_W           = LOG_N + COEF_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [N_TAPS-1:0]       in_bits,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_sum
);
   import split_da_pkg::*;

   localparam int HI_W  = LOG_N + COEF_W - LOW_W;
   localparam int LO_W  = LOG_N + LOW_W;
   localparam int N_GRP = (GROUP_A >= N_TAPS) ? 1 : (N_TAPS + GROUP_A - 1) / GROUP_A;
   localparam int GRP_T = (GROUP_A >= N_TAPS) ? N_TAPS : GROUP_A;

   function automatic int upper_bound(input bit want_max);
      int acc;
      acc = 0;
      for (int i = 0; i < N_TAPS; i++) begin
         int p;
         p = upper_part(COEFS[i], LOW_W);
         if (want_max ? (p > 0) : (p < 0)) acc += p;
      end
      return acc;
   endfunction

   localparam int HI_MIN = upper_bound(1'b0);
   localparam int HI_MAX = upper_bound(1'b1);
   localparam int LO_MAX = N_TAPS * ((1 << LOW_W) - 1);

   // R10 elaboration-time parameter checks
   if (LOW_W <= 0 || LOW_W >= COEF_W) begin : g_bad_split
      $error("LOW_W must lie strictly between 0 and COEF_W");
   end
   if (GROUP_A < 1) begin : g_bad_group
      $error("GROUP_A must be at least 1");
   end
   for (genvar i = 0; i < N_TAPS; i++) begin : g_coef_chk
      if (COEFS[i] < -(1 << (COEF_W-1)) || COEFS[i] >= (1 << (COEF_W-1))) begin : g_wide
         $error("coefficient does not fit COEF_W");
      end
   end

   // upper-part table, one or several tap groups (R8)
   logic signed [HI_W-1:0] grp_word [N_GRP];
   logic signed [HI_W-1:0] hi_word;

   for (genvar g = 0; g < N_GRP; g++) begin : g_upper
      localparam int BASE = g * GRP_T;
      localparam int TAPS = (N_TAPS - BASE < GRP_T) ? (N_TAPS - BASE) : GRP_T;
      logic [HI_W-1:0] w;
      split_da_rom #(
         .NC(N_TAPS), .COEFS(COEFS), .BASE(BASE), .TAPS(TAPS),
         .SPLIT(LOW_W), .UPPER(1'b1), .WORD_W(HI_W)
      ) u_rom (
         .addr(in_bits[BASE +: TAPS]),
         .word(w)
      );
      assign grp_word[g] = $signed(w);
   end

   if (N_GRP == 1) begin : g_hi_single
      assign hi_word = grp_word[0];
   end else begin : g_hi_sum
      always_comb begin
         hi_word = '0;
         for (int g = 0; g < N_GRP; g++) hi_word = hi_word + grp_word[g];
      end
   end

   // lower-part table
   logic [LO_W-1:0] lo_word;

   split_da_rom #(
      .NC(N_TAPS), .COEFS(COEFS), .BASE(0), .TAPS(N_TAPS),
      .SPLIT(LOW_W), .UPPER(1'b0), .WORD_W(LO_W)
   ) u_lower (
      .addr(in_bits),
      .word(lo_word)
   );

   // stage 1: registered lookup
   logic                   s1_vld;
   logic signed [HI_W-1:0] s1_hi;
   logic [LO_W-1:0]        s1_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_hi  <= '0;
         s1_lo  <= '0;
      end else begin
         s1_vld <= in_valid;
         if (in_valid) begin
            s1_hi <= hi_word;
            s1_lo <= lo_word;
         end
      end
   end

   // stage 2: shift and add
   split_da_merge #(
      .HI_W(HI_W), .LO_W(LO_W), .SPLIT(LOW_W), .OUT_W(OUT_W),
      .HI_MIN(HI_MIN), .HI_MAX(HI_MAX), .LO_MAX(LO_MAX)
   ) u_merge (
      .clk(clk),
      .rst_n(rst_n),
      .vld_in(s1_vld),
      .hi_in(s1_hi),
      .lo_in(s1_lo),
      .vld_out(out_valid),
      .sum_out(out_sum)
   );

   // R2
   lookup_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_vld);

endmodule

// File: tb/tb_split_coef_da.sv
module tb_split_coef_da;
   localparam int CLK_P = 10;
   localparam int N     = 6;
   localparam int OW    = 11;
   localparam int CA [N] = '{23, -53, -108, -79, 55, 127};
   localparam int CB [N] = '{-128, 127, -1, 1, -64, 100};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [N-1:0] in_bits = '0;
   logic va, vb;
   logic signed [OW-1:0] sa, sb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   split_coef_da dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
      .out_valid(va), .out_sum(sa)
   );

   // R8: upper table split 4 + 2 taps
   split_coef_da #(.GROUP_A(4), .COEFS(CB)) dut_split (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
      .out_valid(vb), .out_sum(sb)
   );

   function automatic int ref_a(input logic [N-1:0] v);
      int s = 0;
      for (int i = 0; i < N; i++) if (v[i]) s += CA[i];
      return s;
   endfunction

   function automatic int ref_b(input logic [N-1:0] v);
      int s = 0;
      for (int i = 0; i < N; i++) if (v[i]) s += CB[i];
      return s;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // bench pipeline model: entries driven one and two steps ago
   logic q1_v = 1'b0, q2_v = 1'b0;
   logic [N-1:0] q1_d = '0, q2_d = '0;
   string q1_t = "R3", q2_t = "R3";
   int held_a = 0, held_b = 0;

   task automatic step(input logic v, input logic [N-1:0] d, input string tag);
      @(negedge clk);
      check(q2_v ? "R2" : "R2 idle", int'(va), int'(q2_v));
      check(q2_v ? "R2" : "R2 idle", int'(vb), int'(q2_v));
      if (q2_v) begin
         held_a = ref_a(q2_d);
         held_b = ref_b(q2_d);
         check(q2_t, int'(sa), held_a);
         check({q2_t, " R8"}, int'(sb), held_b);
      end else begin
         check("R7", int'(sa), held_a);
         check("R7", int'(sb), held_b);
      end
      q2_v = q1_v; q2_d = q1_d; q2_t = q1_t;
      q1_v = v;    q1_d = d;    q1_t = tag;
      in_valid = v;
      in_bits  = d;
   endtask

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1", int'(va), 0);
      check("R1", int'(sa), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(va), 0);
      check("R1", int'(sb), 0);

      step(1'b1, 6'b000000, "R4");
      step(1'b0, 6'b101010, "R7");
      step(1'b1, 6'b111111, "R5");
      step(1'b0, 6'b010101, "R7");
      // R6: only negative coefficients of dut (taps 1,2,3)
      step(1'b1, 6'b001110, "R6");
      // R6: negative taps of dut_split (0,2,4)
      step(1'b1, 6'b010101, "R6");
      for (int i = 0; i < N; i++) step(1'b1, 6'(1 << i), "R3");
      step(1'b0, 6'b111111, "R7");
      step(1'b0, 6'b000001, "R7");
      // R9: full sweep back to back
      for (int v = 0; v < (1 << N); v++) step(1'b1, 6'(v), "R9");
      // random mix with gaps
      for (int k = 0; k < 300; k++) begin
         logic vv;
         vv = ($urandom % 3) != 0;
         step(vv, 6'($urandom), vv ? "R3" : "R7");
      end
      step(1'b0, '0, "R7");
      step(1'b0, '0, "R7");
      step(1'b0, '0, "R7");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule